// File: doc/BRIEF.md
# Cell Inlet Framing Checker

This block watches the control side of a cell-oriented inlet port and reports violations of start-of-cell framing. It does not capture data. It decides which cycles carry a cell transfer, counts transfers within a cell, and flags a cell that begins without its start marker. It also flags a start marker that appears before the current cell is complete, a data-valid strobe that drops in the middle of a cell, and any cell that arrives while the inlet is offline.

The transfer strobe depends on the operating mode. In ATM-layer emulation and back-to-back operation, the peer's cell-available line qualifies each transfer. In PHY-layer emulation, the block's own enable line qualifies each transfer, and a cell may start only after cell-available has been seen. In the ALI-style mode, a data-valid line qualifies each transfer. Either an 8-bit or a 16-bit data path can be selected. After any error the checker drops the current cell and waits for the next correctly marked start.

Top module: `cell_inlet_chk`

## Requirements
- R1: After reset, every output is 0 and no cell is in progress.
- R2: A cell is 53 qualified transfers when `wide_i`=0 and 27 when `wide_i`=1. The cycle after its last transfer, `cell_done_o` pulses for one cycle and `in_cell_o` is 0.
- R3: `mode_i` is decoded as 0 = ATM-layer emulation, 1 = PHY-layer emulation, 2 = ALI-style, 3 = back-to-back. The transfer strobe is `clav_i` in modes 0 and 3, `enb_i` in mode 1, and `dval_i` in mode 2.
- R4: In modes 0, 2 and 3, a first transfer while idle with `soc_i`=0 raises the missing-marker cause (`err_cause_o` bit 0).
- R5: In mode 1, a cell starts on an `enb_i` cycle while idle, provided `clav_i` is high in that cycle or has been high since the last start. An `enb_i` while idle without that condition is ignored. A start cycle with `soc_i`=0 raises cause bit 0.
- R6: A qualified transfer with `soc_i`=1 inside a cell, before its last transfer, raises the early-marker cause (bit 1).
- R7: With `online_i`=0, a cell arrival raises the offline-arrival cause (bit 2), and no cell starts. Idle cycles raise nothing.
- R8: In mode 2, `dval_i`=0 inside a cell raises the valid-drop cause (bit 3).
- R9: In modes 0, 1 and 3, cycles without a transfer inside a cell are tolerated and are not counted.
- R10: Any error ends the current cell (`in_cell_o`=0 in the cycle the error is reported). The next correctly marked start begins a fresh count.
- R11: `soc_err_o` is a one-cycle pulse, one cycle after the offending transfer. `err_flag_o` is set by any error and holds until `flag_clr_i`; a new error in the same cycle as the clear wins.
- R12: `err_cause_o` is one-hot or zero, and `soc_err_o` is its OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Emulation mode code (R3) |
| wide_i | input | 1 | 1 selects the 16-bit path |
| online_i | input | 1 | 1 accepts cells at the inlet |
| clav_i | input | 1 | Peer cell-available |
| enb_i | input | 1 | Transfer enable (PHY emulation) |
| dval_i | input | 1 | Data-valid (ALI-style) |
| soc_i | input | 1 | Start-of-cell marker |
| flag_clr_i | input | 1 | Clears the sticky flag |
| soc_err_o | output | 1 | Error pulse |
| err_cause_o | output | 4 | One-hot cause: 0 missing, 1 early, 2 offline, 3 valid drop |
| err_flag_o | output | 1 | Sticky error flag |
| cell_done_o | output | 1 | Cell completed pulse |
| in_cell_o | output | 1 | A cell is in progress |

## Verification
The hardest cases to reach are an early marker or a valid drop at every possible position inside a cell. Each one needs a correctly framed prefix of exactly the right length, in every mode and width. The bench sweeps the fault position across the whole cell for each mode and width, and follows every aborted cell with a clean one to show that counting restarts. The remembered cell-available condition in PHY emulation is reached by raising cell-available and enable in separate cycles.

// File: rtl/cell_inlet_pkg.sv
package cell_inlet_pkg;

    typedef enum logic [1:0] {
        MODE_ATM = 2'd0,
        MODE_PHY = 2'd1,
        MODE_ALI = 2'd2,
        MODE_B2B = 2'd3
    } inlet_mode_e;

    // bit 0 missing marker, bit 1 early marker, bit 2 offline arrival, bit 3 valid drop
    typedef struct packed {
        logic drop;
        logic offline;
        logic early;
        logic nosoc;
    } cause_t;

endpackage

// File: rtl/inlet_beat_qual.sv
module inlet_beat_qual
    import cell_inlet_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  inlet_mode_e mode_i,
    input  logic        busy_i,
    input  logic        clav_i,
    input  logic        enb_i,
    input  logic        dval_i,
    output logic        beat_o,
    output logic        arrive_o
);

    typedef struct packed {
        logic armed;
    } qual_t;

    qual_t qual_d, qual_q;

    always_comb begin
        qual_d   = qual_q;
        beat_o   = 1'b0;
        arrive_o = 1'b0;
        unique case (mode_i)
            MODE_ATM, MODE_B2B: begin
                beat_o   = clav_i;
                arrive_o = !busy_i && clav_i;
            end
            MODE_PHY: begin
                beat_o   = enb_i;
                arrive_o = !busy_i && enb_i && (clav_i || qual_q.armed);
            end
            default: begin
                beat_o   = dval_i;
                arrive_o = !busy_i && dval_i;
            end
        endcase
        if (mode_i == MODE_PHY) begin
            qual_d.armed = (qual_q.armed || clav_i) && !arrive_o;
        end else begin
            qual_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            qual_q <= '0;
        end else begin
            qual_q <= qual_d;
        end
    end

endmodule

// File: rtl/inlet_cell_track.sv
module inlet_cell_track
    import cell_inlet_pkg::*;
#(
    parameter int CELL_BYTES = 53
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  inlet_mode_e mode_i,
    input  logic        wide_i,
    input  logic        online_i,
    input  logic        soc_i,
    input  logic        beat_i,
    input  logic        arrive_i,
    output logic        busy_o,
    output logic        last_o,
    output cause_t      cause_o
);

    localparam int LEN_NARROW = CELL_BYTES;
    localparam int LEN_WIDE   = (CELL_BYTES + 1) / 2;
    localparam int CNT_W      = $clog2(CELL_BYTES + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } trk_t;

    trk_t             trk_d, trk_q;
    logic [CNT_W-1:0] cell_len;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        trk_d    = trk_q;
        cause_o  = '0;
        last_o   = 1'b0;
        cell_len = wide_i ? CNT_W'(LEN_WIDE) : CNT_W'(LEN_NARROW);
        cnt_inc  = trk_q.cnt + 1'b1;
        if (!trk_q.busy) begin
            if (arrive_i) begin
                if (!online_i) begin
                    cause_o.offline = 1'b1;
                end else if (!soc_i) begin
                    cause_o.nosoc = 1'b1;
                end else begin
                    trk_d.busy = 1'b1;
                    trk_d.cnt  = CNT_W'(1);
                end
            end
        end else begin
            if (mode_i == MODE_ALI && !beat_i) begin
                cause_o.drop = 1'b1;
                trk_d        = '0;
            end else if (beat_i) begin
                if (soc_i) begin
                    cause_o.early = 1'b1;
                    trk_d         = '0;
                end else if (cnt_inc == cell_len) begin
                    last_o = 1'b1;
                    trk_d  = '0;
                end else begin
                    trk_d.cnt = cnt_inc;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign busy_o = trk_q.busy;

endmodule

// File: rtl/inlet_err_report.sv
module inlet_err_report
    import cell_inlet_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  cause_t cause_i,
    input  logic   last_i,
    input  logic   flag_clr_i,
    output cause_t cause_o,
    output logic   flag_o,
    output logic   done_o
);

    typedef struct packed {
        cause_t cause;
        logic   flag;
        logic   done;
    } rep_t;

    rep_t rep_d, rep_q;

    always_comb begin
        rep_d       = rep_q;
        rep_d.cause = cause_i;
        rep_d.done  = last_i;
        rep_d.flag  = (|cause_i) || (rep_q.flag && !flag_clr_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rep_q <= '0;
        end else begin
            rep_q <= rep_d;
        end
    end

    assign cause_o = rep_q.cause;
    assign flag_o  = rep_q.flag;
    assign done_o  = rep_q.done;

endmodule

// File: rtl/cell_inlet_chk.sv
module cell_inlet_chk
    import cell_inlet_pkg::*;
#(
    parameter int CELL_BYTES = 53
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] mode_i,
    input  logic       wide_i,
    input  logic       online_i,
    input  logic       clav_i,
    input  logic       enb_i,
    input  logic       dval_i,
    input  logic       soc_i,
    input  logic       flag_clr_i,
    output logic       soc_err_o,
    output logic [3:0] err_cause_o,
    output logic       err_flag_o,
    output logic       cell_done_o,
    output logic       in_cell_o
);

    inlet_mode_e mode;
    logic        busy;
    logic        beat;
    logic        arrive;
    logic        last;
    cause_t      cause_now;
    cause_t      cause_reg;

    assign mode = inlet_mode_e'(mode_i);

    inlet_beat_qual i_qual (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .mode_i   (mode),
        .busy_i   (busy),
        .clav_i   (clav_i),
        .enb_i    (enb_i),
        .dval_i   (dval_i),
        .beat_o   (beat),
        .arrive_o (arrive)
    );

    inlet_cell_track #(
        .CELL_BYTES (CELL_BYTES)
    ) i_track (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .mode_i   (mode),
        .wide_i   (wide_i),
        .online_i (online_i),
        .soc_i    (soc_i),
        .beat_i   (beat),
        .arrive_i (arrive),
        .busy_o   (busy),
        .last_o   (last),
        .cause_o  (cause_now)
    );

    inlet_err_report i_report (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cause_i    (cause_now),
        .last_i     (last),
        .flag_clr_i (flag_clr_i),
        .cause_o    (cause_reg),
        .flag_o     (err_flag_o),
        .done_o     (cell_done_o)
    );

    assign err_cause_o = cause_reg;
    assign soc_err_o   = |cause_reg;
    assign in_cell_o   = busy;

endmodule

module cell_inlet_chk_sva (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [1:0] mode_i,
    input logic       online_i,
    input logic       soc_i,
    input logic       flag_clr_i,
    input logic       soc_err_o,
    input logic [3:0] err_cause_o,
    input logic       err_flag_o,
    input logic       cell_done_o,
    input logic       in_cell_o
);

    // R12
    cause_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(err_cause_o));

    // R11
    err_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soc_err_o |=> err_flag_o);

    // R11
    flag_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(err_flag_o) |-> $past(flag_clr_i));

    // R10
    err_abandons_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soc_err_o |-> !in_cell_o);

    // R2
    done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cell_done_o |-> (!in_cell_o && $past(in_cell_o)));

    // R7
    offline_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_cause_o[2] |-> !$past(online_i));

    // R8
    drop_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_cause_o[3] |-> ($past(mode_i) == 2'd2 && $past(in_cell_o)));

    // R6
    early_ctx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_cause_o[1] |-> ($past(in_cell_o) && $past(soc_i)));

    // R4
    nosoc_ctx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_cause_o[0] |-> (!$past(in_cell_o) && !$past(soc_i)));

endmodule

bind cell_inlet_chk cell_inlet_chk_sva i_sva (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .online_i    (online_i),
    .soc_i       (soc_i),
    .flag_clr_i  (flag_clr_i),
    .soc_err_o   (soc_err_o),
    .err_cause_o (err_cause_o),
    .err_flag_o  (err_flag_o),
    .cell_done_o (cell_done_o),
    .in_cell_o   (in_cell_o)
);

// File: tb/test_cell_inlet_chk.sv
`timescale 1ns/1ps
module test_cell_inlet_chk;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       wide = 1'b0;
    logic       online = 1'b1;
    logic       clav = 1'b0;
    logic       enb = 1'b0;
    logic       dval = 1'b0;
    logic       soc = 1'b0;
    logic       clr = 1'b0;
    logic       err;
    logic [3:0] cause;
    logic       flag;
    logic       done;
    logic       in_cell;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    cell_inlet_chk i_cell_inlet_chk (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .mode_i      (mode),
        .wide_i      (wide),
        .online_i    (online),
        .clav_i      (clav),
        .enb_i       (enb),
        .dval_i      (dval),
        .soc_i       (soc),
        .flag_clr_i  (clr),
        .soc_err_o   (err),
        .err_cause_o (cause),
        .err_flag_o  (flag),
        .cell_done_o (done),
        .in_cell_o   (in_cell)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run = n_run + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s mode=%0d wide=%0d: actual %0h expected %0h", tag, mode, wide, act, exp);
        end
    endtask

    // drive one cycle, sample 1 ns after the capturing edge
    task automatic cyc(input logic c, input logic e, input logic d, input logic s);
        @(negedge clk);
        clav = c; enb = e; dval = d; soc = s;
        @(posedge clk);
        #1;
    endtask

    task automatic data_beat(input logic first, input logic s);
        case (mode)
            2'd1:    cyc(first, 1'b1, 1'b0, s);
            2'd2:    cyc(1'b0, 1'b0, 1'b1, s);
            default: cyc(1'b1, 1'b0, 1'b0, s);
        endcase
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    function automatic logic [7:0] obs();
        return {1'b0, in_cell, done, err, cause};
    endfunction

    // expected observation word: {0, in_cell, done, err, cause}
    function automatic logic [7:0] expw(input logic ic, input logic dn, input logic [3:0] c);
        return {1'b0, ic, dn, |c, c};
    endfunction

    task automatic good_cell(input int len, input string tag);
        logic bad;
        bad = 1'b0;
        for (int i = 0; i < len; i++) begin
            data_beat(i == 0, i == 0);
            if (i < len - 1) begin
                if (obs() !== expw(1'b1, 1'b0, 4'h0)) bad = 1'b1;
            end else begin
                chk({tag, " last beat"}, obs(), expw(1'b0, 1'b1, 4'h0));
            end
        end
        chk({tag, " body"}, {7'd0, bad}, 8'd0);
    endtask

    initial begin
        int len;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 reset outputs", {obs()[6:0], flag}, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;
        idle();
        chk("R1 idle after reset", {obs()[6:0], flag}, 8'd0);

        for (int m = 0; m < 4; m++) begin
            for (int w = 0; w < 2; w++) begin
                mode = 2'(m);
                wide = 1'(w);
                len  = (w == 1) ? 27 : 53;
                idle();
                // R2 R3 full cell length per mode and width
                good_cell(len, "R2 R3 good cell");
                // back-to-back clean cell straight after
                good_cell(len, "R2 back-to-back cell");

                // R6 early marker at every position, R10 fresh start afterwards
                for (int k = 1; k < len; k++) begin
                    data_beat(1'b1, 1'b1);
                    for (int j = 1; j < k; j++) data_beat(1'b0, 1'b0);
                    data_beat(1'b0, 1'b1);
                    chk("R6 R10 early marker", obs(), expw(1'b0, 1'b0, 4'b0010));
                    idle();
                end
                good_cell(len, "R10 restart after abort");

                if (m == 2) begin
                    // R8 valid drop at every position
                    for (int k = 1; k < len; k++) begin
                        data_beat(1'b1, 1'b1);
                        for (int j = 1; j < k; j++) data_beat(1'b0, 1'b0);
                        idle();
                        chk("R8 valid drop", obs(), expw(1'b0, 1'b0, 4'b1000));
                    end
                end else begin
                    // R9 gaps inside a cell are tolerated and uncounted
                    for (int i = 0; i < len; i++) begin
                        data_beat(i == 0, i == 0);
                        if (i == len / 2) begin
                            idle(); idle(); idle();
                            chk("R9 gap tolerated", obs(), expw(1'b1, 1'b0, 4'h0));
                        end
                    end
                    chk("R9 done after gap", obs(), expw(1'b0, 1'b1, 4'h0));
                end

                // R4 R5 missing marker at start
                data_beat(1'b1, 1'b0);
                chk("R4 R5 missing marker", obs(), expw(1'b0, 1'b0, 4'b0001));
                idle();

                // R7 offline arrival and quiet offline idle
                online = 1'b0;
                idle();
                chk("R7 offline idle quiet", obs(), expw(1'b0, 1'b0, 4'h0));
                data_beat(1'b1, 1'b1);
                chk("R7 offline arrival", obs(), expw(1'b0, 1'b0, 4'b0100));
                online = 1'b1;
                idle();

                if (m == 1) begin
                    // R5 enable without prior cell-available is ignored
                    cyc(1'b0, 1'b1, 1'b0, 1'b0);
                    chk("R5 enable ignored", obs(), expw(1'b0, 1'b0, 4'h0));
                    // R5 remembered cell-available, start on later enable
                    cyc(1'b1, 1'b0, 1'b0, 1'b0);
                    idle();
                    cyc(1'b0, 1'b1, 1'b0, 1'b1);
                    chk("R5 armed start", obs(), expw(1'b1, 1'b0, 4'h0));
                    for (int i = 1; i < len; i++) data_beat(1'b0, 1'b0);
                    chk("R5 armed cell done", obs(), expw(1'b0, 1'b1, 4'h0));
                end

                // R11 sticky flag and clear
                chk("R11 flag held", {7'd0, flag}, 8'd1);
                @(negedge clk); clr = 1'b1;
                idle();
                clr = 1'b0;
                chk("R11 flag cleared", {7'd0, flag}, 8'd0);
                // R11 set wins over clear
                @(negedge clk); clr = 1'b1;
                data_beat(1'b1, 1'b0);
                clr = 1'b0;
                chk("R11 R12 set wins", {6'd0, flag, err}, 8'd3);
                idle();
                chk("R11 pulse one cycle", {6'd0, flag, err}, 8'd2);
                @(negedge clk); clr = 1'b1;
                idle();
                clr = 1'b0;
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule